// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a ring of transmit descriptors that lives in memory and hands each descriptor's words downstream. Software sets a ring start address, the ring size and a tail address through a small write port, then sets a run bit. The engine reads descriptors one after another, starting at the ring start. Each descriptor is four 32-bit words at consecutive addresses, with a 16-byte stride between descriptors. Each word fetched over the memory read port is presented on a valid/ready output stream.

Which descriptors hardware may process is set only by the tail. Everything from the current descriptor up to, but not including, the descriptor the tail addresses belongs to the engine. When the current descriptor reaches the tail, the engine suspends and stops issuing reads. It leaves that state only when software writes a tail that lies at a different ring position. After the last descriptor of the ring, the current position returns to the ring start. A status output shows idle, running or suspended, and a single-cycle strobe marks every entry into suspension.

Top module: `txd_ring_fetch`

## Requirements
- R1: After reset the status reads idle (0), no memory read is requested, the output stream is not valid, the suspend strobe is low and the current-descriptor address is 0.
- R2: Writes select a register with `cfg_sel`: 0 is control (bit 0 = run), 1 is the ring start address, 2 is the ring size as descriptor count minus one, and 3 is the tail address. `cur_addr` always equals ring start + 16 × current ring index.
- R3: Each descriptor is fetched as four word reads at `cur_addr`, +4, +8 and +12, in that order, with one read outstanding at a time. Every response appears on the output stream in order, and `out_last` is set on the fourth word only.
- R4: A pending read request keeps its valid and address until accepted. A pending output word keeps its valid and data until accepted.
- R5: The current ring index changes only on the cycle after the fourth word of a descriptor is accepted, or when the engine returns to idle.
- R6: Advancing past ring index count−1 returns the current index to 0, which is the ring start address.
- R7: When the current index equals the tail index, the status reads suspended (2), no read is requested, and `suspend_pulse` is high for exactly the first cycle of that state.
- R8: While suspended, only a tail write whose ring index differs from the current index resumes fetching, with status running (1) from the second cycle after the write. A tail write equal to the current index leaves the engine suspended.
- R9: The tail ring index is (tail − start)/16. When that value is count or more, count is subtracted once, so a tail at the end-of-ring address means index 0.
- R10: Clearing run takes effect in suspension or once the descriptor in progress has delivered its fourth word. The engine then goes idle with its index reset, so the next start fetches from the ring start.
- R11: Setting run while the tail index equals the current index enters suspension directly, with one strobe and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cur_addr | output | 32 | Address of the current descriptor |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Descriptor word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Descriptor word |
| out_last | output | 1 | Fourth word of a descriptor |
| status | output | 2 | 0 idle, 1 running, 2 suspended |
| suspend_pulse | output | 1 | One-cycle strobe on entry into suspension |

## Verification
A register write lands on the clock edge where it is sampled, and the engine reacts one edge later, so a resume shows as running on the second edge after a tail write. A request is accepted on an edge, and its response captured one edge later appears as a valid output word. The index moves on the edge that accepts the fourth word. For that reason the bench waits on the status port and samples away from the edge only after suspension is reached, and it checks the logged stream and `cur_addr` at that point. Handshake holding and the pointer-move rule are watched at every edge by bench monitors under random-looking backpressure.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_OUT,
    S_SUSP
  } fetch_st_e;

  localparam logic [1:0] STAT_IDLE = 2'd0;
  localparam logic [1:0] STAT_RUN  = 2'd1;
  localparam logic [1:0] STAT_SUSP = 2'd2;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_SIZE  = 2'd2;
  localparam logic [1:0] SEL_TAIL  = 2'd3;

endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic             run_o,
  output logic [AW-1:0]    start_o,
  output logic [IDX_W-1:0] last_o,
  output logic [AW-1:0]    tail_o,
  output logic             tail_upd_o
);

  logic             run_q, run_d;
  logic [AW-1:0]    start_q, start_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [AW-1:0]    tail_q, tail_d;
  logic             upd_q, upd_d;

  always_comb begin
    run_d   = run_q;
    start_d = start_q;
    last_d  = last_q;
    tail_d  = tail_q;
    upd_d   = 1'b0;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_CTRL:  run_d   = cfg_wdata[0];
        SEL_START: start_d = cfg_wdata;
        SEL_SIZE:  last_d  = cfg_wdata[IDX_W-1:0];
        default: begin
          tail_d = cfg_wdata;
          upd_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= '0;
      last_q  <= '0;
      tail_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      start_q <= start_d;
      last_q  <= last_d;
      tail_q  <= tail_d;
      upd_q   <= upd_d;
    end
  end

  assign run_o      = run_q;
  assign start_o    = start_q;
  assign last_o     = last_q;
  assign tail_o     = tail_q;
  assign tail_upd_o = upd_q;

  // R8: the wake strobe follows only a tail write
  a_r8_upd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tail_upd_o |-> $past(cfg_we) && ($past(cfg_sel) == SEL_TAIL));

endmodule

// File: rtl/txd_tailmap.sv
module txd_tailmap #(
  parameter int AW    = 32,
  parameter int IDX_W = 8,
  parameter int SH    = 4
) (
  input  logic [AW-1:0]    start_i,
  input  logic [AW-1:0]    tail_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] tail_idx_o
);

  logic [AW-1:0]    diff;
  logic [IDX_W-1:0] off;

  always_comb begin
    diff = tail_i - start_i;
    off  = IDX_W'(diff >> SH);
    if (off > last_i) tail_idx_o = off - last_i - IDX_W'(1);
    else              tail_idx_o = off;
  end

endmodule

// File: rtl/txd_ctl.sv
module txd_ctl
  import txd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [AW-1:0]    start_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [IDX_W-1:0] tail_idx_i,
  input  logic             tail_upd_i,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic [AW-1:0]    cur_addr,
  output logic [1:0]       status,
  output logic             suspend_pulse
);

  localparam int WSEL_W = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
  localparam int BSH    = $clog2(DW / 8);
  localparam int SH     = $clog2(DESC_WORDS * DW / 8);
  localparam logic [WSEL_W-1:0] WSEL_LAST = WSEL_W'(DESC_WORDS - 1);

  fetch_st_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_inc;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [DW-1:0]     dat_q;
  logic              dat_en;
  logic              pulse_q, pulse_d;

  assign idx_inc = (idx_q == last_i) ? '0 : idx_q + IDX_W'(1);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    wsel_d  = wsel_q;
    dat_en  = 1'b0;
    pulse_d = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        idx_d  = '0;
        wsel_d = '0;
        if (run_i) begin
          if (tail_idx_i == idx_q) begin
            st_d    = S_SUSP;
            pulse_d = 1'b1;
          end else begin
            st_d = S_REQ;
          end
        end
      end
      S_REQ: begin
        if (mem_req_ready) st_d = S_WAIT;
      end
      S_WAIT: begin
        if (mem_rsp_valid) begin
          dat_en = 1'b1;
          st_d   = S_OUT;
        end
      end
      S_OUT: begin
        if (out_ready) begin
          if (wsel_q == WSEL_LAST) begin
            wsel_d = '0;
            if (!run_i) begin
              st_d  = S_IDLE;
              idx_d = '0;
            end else begin
              idx_d = idx_inc;
              if (idx_inc == tail_idx_i) begin
                st_d    = S_SUSP;
                pulse_d = 1'b1;
              end else begin
                st_d = S_REQ;
              end
            end
          end else begin
            wsel_d = wsel_q + WSEL_W'(1);
            st_d   = S_REQ;
          end
        end
      end
      S_SUSP: begin
        if (!run_i) begin
          st_d  = S_IDLE;
          idx_d = '0;
        end else if (tail_upd_i && (tail_idx_i != idx_q)) begin
          st_d = S_REQ;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      wsel_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      wsel_q  <= wsel_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= mem_rsp_data;
  end

  assign cur_addr      = start_i + (AW'(idx_q) << SH);
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = cur_addr + (AW'(wsel_q) << BSH);
  assign out_valid     = (st_q == S_OUT);
  assign out_data      = dat_q;
  assign out_last      = (wsel_q == WSEL_LAST);
  assign suspend_pulse = pulse_q;

  always_comb begin
    unique case (st_q)
      S_IDLE:  status = STAT_IDLE;
      S_SUSP:  status = STAT_SUSP;
      default: status = STAT_RUN;
    endcase
  end

  // R4: request and output words hold until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R5: the index holds unless a descriptor completes or the engine stops
  a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) && run_i && !(out_valid && out_ready && out_last) |=> $stable(idx_q));
  // R6: the index never leaves the ring
  a_r6_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> idx_q <= last_i);
  // R7: no fetch while suspended; strobe is a single cycle at entry
  a_r7_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_SUSP) |-> !mem_req_valid);
  a_r7_pulse_state: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> status == STAT_SUSP);
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |=> !suspend_pulse);
  // R9: the mapped tail lies inside the ring once running
  a_r9_tail_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> tail_idx_i <= last_i);

endmodule

// File: rtl/txd_ring_fetch.sv
module txd_ring_fetch #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cur_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [1:0]    status,
  output logic          suspend_pulse
);

  localparam int SH = $clog2(DESC_WORDS * DW / 8);

  logic             run;
  logic [AW-1:0]    start;
  logic [IDX_W-1:0] last;
  logic [AW-1:0]    tail;
  logic             tail_upd;
  logic [IDX_W-1:0] tail_idx;

  txd_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .run_o      (run),
    .start_o    (start),
    .last_o     (last),
    .tail_o     (tail),
    .tail_upd_o (tail_upd)
  );

  txd_tailmap #(.AW(AW), .IDX_W(IDX_W), .SH(SH)) u_tmap (
    .start_i    (start),
    .tail_i     (tail),
    .last_i     (last),
    .tail_idx_o (tail_idx)
  );

  txd_ctl #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .DESC_WORDS(DESC_WORDS)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .start_i       (start),
    .last_i        (last),
    .tail_idx_i    (tail_idx),
    .tail_upd_i    (tail_upd),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_last      (out_last),
    .cur_addr      (cur_addr),
    .status        (status),
    .suspend_pulse (suspend_pulse)
  );

endmodule

// File: tb/txd_ring_fetch_tb.sv
module txd_ring_fetch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cur_addr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_last;
  logic [1:0]  status;
  logic        suspend_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit stall = 0;
  logic [7:0] cyc = '0;

  logic [31:0] log_d [0:255];
  logic        log_l [0:255];
  int nlog = 0;
  int nreq = 0;
  int npulse = 0;
  int viol4 = 0;
  int viol5 = 0;
  bit hold_req = 0, hold_out = 0, acc_last_prev = 0;
  logic [31:0] prev_raddr = '0, prev_odata = '0, prev_cur = '0;

  always #5 clk = ~clk;

  txd_ring_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cur_addr(cur_addr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .status(status), .suspend_pulse(suspend_pulse)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  assign mem_req_ready = !stall || cyc[0];
  assign out_ready     = !stall || cyc[1] || cyc[3];

  // memory model and stream monitors
  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= memf(mem_req_addr);
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
      if (suspend_pulse) npulse <= npulse + 1;
      if (out_valid && out_ready) begin
        log_d[nlog[7:0]] <= out_data;
        log_l[nlog[7:0]] <= out_last;
        nlog <= nlog + 1;
      end
      if (hold_req && !(mem_req_valid && mem_req_addr == prev_raddr)) viol4 <= viol4 + 1;
      if (hold_out && !(out_valid && out_data == prev_odata)) viol4 <= viol4 + 1;
      if (status != 2'd0 && cur_addr != prev_cur && !acc_last_prev) viol5 <= viol5 + 1;
      hold_req      <= mem_req_valid && !mem_req_ready;
      hold_out      <= out_valid && !out_ready;
      prev_raddr    <= mem_req_addr;
      prev_odata    <= out_data;
      prev_cur      <= cur_addr;
      acc_last_prev <= out_valid && out_ready && out_last;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_status(input logic [1:0] want, input string req);
    bit seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status == want) begin seen = 1; break; end
    end
    check(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic check_desc(input string req, input int start, input logic [31:0] base,
                            input int first, input int cnt, input int n);
    for (int d = 0; d < n; d++) begin
      int idx = (first + d) % cnt;
      for (int w = 0; w < 4; w++) begin
        check(req, log_d[start + d*4 + w], memf(base + 32'(idx*16 + w*4)));
        check(req, {31'd0, log_l[start + d*4 + w]}, {31'd0, w == 3});
      end
    end
  endtask

  // {start, count-1, tail, descriptors expected}
  localparam logic [127:0] VEC [0:4] = '{
    {32'h1000, 32'd7,  32'h1030, 32'd3},
    {32'h2000, 32'd3,  32'h2040, 32'd0},
    {32'h3000, 32'd0,  32'h3000, 32'd0},
    {32'h4000, 32'd15, 32'h40F0, 32'd15},
    {32'h5000, 32'd2,  32'h5050, 32'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", {30'd0, status}, 32'd0);
    check("R1 req", {31'd0, mem_req_valid}, 32'd0);
    check("R1 out", {31'd0, out_valid}, 32'd0);
    check("R1 pulse", {31'd0, suspend_pulse}, 32'd0);
    check("R1 cur", cur_addr, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 5; v++) begin
      logic [31:0] b, l, t, nd;
      int s, p0;
      {b, l, t, nd} = VEC[v];
      stall = v[0];
      cfg_write(2'd0, 32'd0);
      repeat (2) @(negedge clk);
      check("R10 idle after stop", {30'd0, status}, 32'd0);
      cfg_write(2'd1, b);
      cfg_write(2'd2, l);
      cfg_write(2'd3, t);
      check("R2 cur at start", cur_addr, b);
      s = nlog; p0 = npulse;
      cfg_write(2'd0, 32'd1);
      wait_status(2'd2, "R7 reach suspend");
      repeat (2) @(negedge clk);
      // R3 words; R9 / R11 cover the zero-descriptor and wrapped-tail rows
      check(nd == 0 ? "R11 word count" : (v == 4 ? "R9 word count" : "R3 word count"),
            32'(nlog - s), nd * 4);
      check_desc("R3 data", s, b, 0, int'(l) + 1, int'(nd));
      check("R2 cur after run", cur_addr, b + nd * 16);
      check("R7 one pulse", 32'(npulse - p0), 32'd1);
    end

    begin
      int s, p0, r0;
      // R8: tail write equal to current index keeps suspension
      r0 = nreq;
      cfg_write(2'd3, 32'h5020);
      repeat (20) @(negedge clk);
      check("R8 no wake", {30'd0, status}, 32'd2);
      check("R8 no reads", 32'(nreq - r0), 32'd0);
      // R6 wrap: index 2, then 0, stop at 1
      s = nlog; p0 = npulse;
      cfg_write(2'd3, 32'h5010);
      @(negedge clk);
      check("R8 resume", {30'd0, status}, 32'd1);
      wait_status(2'd2, "R6 suspend after wrap");
      repeat (2) @(negedge clk);
      check("R6 word count", 32'(nlog - s), 32'd8);
      check_desc("R6 wrap data", s, 32'h5000, 2, 3, 2);
      check("R6 cur", cur_addr, 32'h5010);
      check("R7 pulse", 32'(npulse - p0), 32'd1);
      // R10 stop from suspension, restart from ring start
      cfg_write(2'd0, 32'd0);
      repeat (2) @(negedge clk);
      check("R10 idle", {30'd0, status}, 32'd0);
      check("R10 cur reset", cur_addr, 32'h5000);
      s = nlog;
      cfg_write(2'd0, 32'd1);
      wait_status(2'd2, "R10 restart suspend");
      repeat (2) @(negedge clk);
      check("R10 restart count", 32'(nlog - s), 32'd4);
      check_desc("R10 restart data", s, 32'h5000, 0, 3, 1);
      // R10 stop mid-descriptor finishes the descriptor; tail at end of ring (R9)
      stall = 1;
      s = nlog;
      cfg_write(2'd3, 32'h5030);
      cfg_write(2'd0, 32'd0);
      wait_status(2'd0, "R10 reach idle");
      repeat (2) @(negedge clk);
      check("R10 finish descriptor", 32'(nlog - s), 32'd4);
      check_desc("R10 finish data", s, 32'h5000, 1, 3, 1);
      check("R10 cur base", cur_addr, 32'h5000);
      check("R4 handshake hold", 32'(viol4), 32'd0);
      check("R5 pointer moves", 32'(viol5), 32'd0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule